// File: doc/BRIEF.md
# Adder-Cell Logic and Arithmetic Unit

This block is a small arithmetic and logic unit. It is built from a row of one-bit full-adder cells. Two operands and a function code go in, and a result word and a carry-out come back in the same cycle. The block is purely combinational and holds no state.

Addition and subtraction let the carry ripple through the cells. Subtraction feeds in the inverted second operand and a carry of one. The four logic functions need no separate gates. Each cell's incoming carry is tied to a constant instead of the carry from the cell below. With a constant of 0, the sum outputs give exclusive-OR and the carry outputs give AND. With a constant of 1, the sum outputs give exclusive-NOR and the carry outputs give OR. A decoder turns the function code into these cell controls. An output stage then picks either the sum bits or the carry bits.

The block has no stored data and no transfer to pace, so it has no handshake. All of its pins are plain levels.

Top module: `cellalu_top`

## Requirements
- R1: With function code 3'b000 (add), `{carry_out, result}` equals `opa + opb + carry_in`, taken over WIDTH+1 bits.
- R2: With function code 3'b001 (subtract), `{carry_out, result}` equals `opa + ~opb + 1` over WIDTH+1 bits. `carry_in` has no effect in this mode. A `carry_out` of 1 means `opa >= opb`, so no borrow occurred.
- R3: With function code 3'b010, `result` is the bitwise exclusive-OR of `opa` and `opb`.
- R4: With function code 3'b011, `result` is the bitwise exclusive-NOR of `opa` and `opb`.
- R5: With function code 3'b100, `result` is the bitwise AND of `opa` and `opb`.
- R6: With function code 3'b101, `result` is the bitwise OR of `opa` and `opb`.
- R7: In the four logic modes (codes 3'b010 to 3'b101), `carry_out` is 0 and `carry_in` has no effect on either output.
- R8: With function codes 3'b110 and 3'b111, `result` and `carry_out` are both 0 for every operand pair and carry value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand; the subtrahend in subtract mode |
| func | input | 3 | Function code |
| carry_in | input | 1 | Carry into the lowest cell; used only in add mode |
| result | output | WIDTH | Result word |
| carry_out | output | 1 | Carry out of the top cell in add and subtract modes; 0 in all other modes |

## Verification
Every pair of operands is applied with both carry values under each of the eight function codes.

- In add mode, the sweep covers the all-ones plus one wrap and the carry-in-only increment. Together these separate a correct ripple chain from a broken link between cells.
- In subtract mode, equal operands, a larger `opa` and a smaller `opa` show whether `carry_out` follows the no-borrow rule.
- Toggling `carry_in` in every mode other than add shows that the forced cell carries really cut off the external carry.
- Operand pairs with equal and unequal bits in every position tell the sum-side functions (exclusive-OR, exclusive-NOR) apart from the carry-side functions (AND, OR).

// File: rtl/cellalu_pkg.sv
package cellalu_pkg;

  // Function codes
  typedef enum logic [2:0] {
    FN_ADD  = 3'b000,
    FN_SUB  = 3'b001,
    FN_XOR  = 3'b010,
    FN_XNOR = 3'b011,
    FN_AND  = 3'b100,
    FN_OR   = 3'b101
  } fn_e;

  // Controls for the cell row and the output stage
  typedef struct packed {
    logic invert_b;   // feed ~opb to the cells
    logic ripple;     // cells chain their carries
    logic force_val;  // constant carry into every cell when not rippling
    logic low_carry;  // carry into the lowest cell when rippling
    logic take_carry; // result comes from the cell carries, not the sums
    logic cout_en;    // pass the top cell's carry to carry_out
    logic blank;      // unused code: zero everything
  } ctl_t;

endpackage

// File: rtl/cellalu_cell.sv
module cellalu_cell (
  input  logic a,
  input  logic b,
  input  logic ci,
  output logic s,
  output logic co
);
  logic half;

  always_comb begin
    half = a ^ b;
    s    = half ^ ci;
    co   = (a & b) | (half & ci);
  end
endmodule

// File: rtl/cellalu_decode.sv
module cellalu_decode
  import cellalu_pkg::*;
(
  input  logic [2:0] func,
  input  logic       carry_in,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '0;
    case (fn_e'(func))
      FN_ADD: begin
        ctl.ripple    = 1'b1;
        ctl.low_carry = carry_in;
        ctl.cout_en   = 1'b1;
      end
      FN_SUB: begin
        ctl.ripple    = 1'b1;
        ctl.invert_b  = 1'b1;
        ctl.low_carry = 1'b1;
        ctl.cout_en   = 1'b1;
      end
      FN_XOR:  ctl.force_val = 1'b0;
      FN_XNOR: ctl.force_val = 1'b1;
      FN_AND: begin
        ctl.force_val  = 1'b0;
        ctl.take_carry = 1'b1;
      end
      FN_OR: begin
        ctl.force_val  = 1'b1;
        ctl.take_carry = 1'b1;
      end
      default: ctl.blank = 1'b1;
    endcase
  end
endmodule

// File: rtl/cellalu_row.sv
module cellalu_row #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             invert_b,
  input  logic             ripple,
  input  logic             force_val,
  input  logic             low_carry,
  output logic [WIDTH-1:0] sums,
  output logic [WIDTH-1:0] carries,
  output logic             top_carry
);
  localparam int LINKS = WIDTH + 1;

  logic [LINKS-1:0] chain;
  logic [WIDTH-1:0] b_eff;

  assign b_eff    = invert_b ? ~b : b;
  assign chain[0] = low_carry;

  for (genvar k = 0; k < WIDTH; k++) begin : g_bit
    logic cin_k;
    // rippling modes take the neighbour's carry, logic modes a constant
    assign cin_k = ripple ? chain[k] : force_val;
    cellalu_cell u_cell (
      .a  (a[k]),
      .b  (b_eff[k]),
      .ci (cin_k),
      .s  (sums[k]),
      .co (chain[k+1])
    );
    assign carries[k] = chain[k+1];
  end

  assign top_carry = chain[WIDTH];
endmodule

// File: rtl/cellalu_top.sv
module cellalu_top
  import cellalu_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic [2:0]       func,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             carry_out
);
  ctl_t             ctl;
  logic [WIDTH-1:0] sums;
  logic [WIDTH-1:0] carries;
  logic             top_carry;

  cellalu_decode u_dec (
    .func     (func),
    .carry_in (carry_in),
    .ctl      (ctl)
  );

  cellalu_row #(.WIDTH(WIDTH)) u_row (
    .a         (opa),
    .b         (opb),
    .invert_b  (ctl.invert_b),
    .ripple    (ctl.ripple),
    .force_val (ctl.force_val),
    .low_carry (ctl.low_carry),
    .sums      (sums),
    .carries   (carries),
    .top_carry (top_carry)
  );

  always_comb begin
    if (ctl.blank) begin
      result    = '0;
      carry_out = 1'b0;
    end else begin
      result    = ctl.take_carry ? carries : sums;
      carry_out = ctl.cout_en & top_carry;
    end
  end
endmodule

// File: rtl/cellalu_check.sv
module cellalu_check #(
  parameter int WIDTH = 4
) (
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic [2:0]       func,
  input logic             carry_in,
  input logic [WIDTH-1:0] result,
  input logic             carry_out
);
  localparam int WW = WIDTH + 1;

  logic [WW-1:0] add_ref;
  logic [WW-1:0] sub_ref;

  always_comb begin
    add_ref = {1'b0, opa} + {1'b0, opb} + WW'(carry_in);
    sub_ref = {1'b0, opa} + {1'b0, ~opb} + WW'(1);
    if (func == 3'b000)
      assert_add_R1: assert ({carry_out, result} == add_ref);
    if (func == 3'b001)
      assert_sub_R2: assert ({carry_out, result} == sub_ref && carry_out == (opa >= opb));
    if (func == 3'b010)
      assert_xor_R3: assert (result == (opa ^ opb));
    if (func == 3'b011)
      assert_xnor_R4: assert (result == ~(opa ^ opb));
    if (func == 3'b100)
      assert_and_R5: assert (result == (opa & opb));
    if (func == 3'b101)
      assert_or_R6: assert (result == (opa | opb));
    if (func >= 3'b010 && func <= 3'b101)
      assert_logic_nocarry_R7: assert (!carry_out);
    if (func >= 3'b110)
      assert_unused_zero_R8: assert (result == '0 && !carry_out);
  end
endmodule

bind cellalu_top cellalu_check #(.WIDTH(WIDTH)) u_check (
  .opa       (opa),
  .opb       (opb),
  .func      (func),
  .carry_in  (carry_in),
  .result    (result),
  .carry_out (carry_out)
);

// File: tb/test_cellalu_top.sv
module test_cellalu_top;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] opa = '0;
  logic [W-1:0] opb = '0;
  logic [2:0]   func = 3'b000;
  logic         carry_in = 1'b0;
  logic [W-1:0] result;
  logic         carry_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  cellalu_top #(.WIDTH(W)) i_cellalu_top (
    .opa       (opa),
    .opb       (opb),
    .func      (func),
    .carry_in  (carry_in),
    .result    (result),
    .carry_out (carry_out)
  );

  function automatic string tag_of(input int f);
    case (f)
      0: return "R1";
      1: return "R2";
      2: return "R3";
      3: return "R4";
      4: return "R5";
      5: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s func=%0d a=%0d b=%0d cin=%0d got=%0d exp=%0d",
               req, func, opa, opb, carry_in, got, exp);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // idle state: zero operands in add mode give a zero result
    @(posedge clk); #1;
    check("R1", {27'd0, carry_out, result}, 0);
    for (int f = 0; f < 8; f++) begin
      for (int a = 0; a <= MASK; a++) begin
        for (int b = 0; b <= MASK; b++) begin
          for (int c = 0; c < 2; c++) begin
            int er;
            int ec;
            @(negedge clk);
            func = 3'(f); opa = W'(a); opb = W'(b); carry_in = c[0];
            case (f)
              0: begin er = (a + b + c) & MASK; ec = ((a + b + c) >> W) & 1; end
              1: begin
                er = (a + ((~b) & MASK) + 1) & MASK;
                ec = ((a + ((~b) & MASK) + 1) >> W) & 1;
              end
              2: begin er = a ^ b;            ec = 0; end
              3: begin er = (~(a ^ b)) & MASK; ec = 0; end
              4: begin er = a & b;            ec = 0; end
              5: begin er = a | b;            ec = 0; end
              default: begin er = 0;          ec = 0; end
            endcase
            @(posedge clk); #1;
            check(tag_of(f), int'(result), er);
            if (f >= 2 && f <= 5)
              check("R7", int'(carry_out), 0);  // R7: logic modes never carry
            else
              check(tag_of(f), int'(carry_out), ec);
            if (f == 1)  // R2: no-borrow meaning of carry_out
              check("R2", int'(carry_out), (a >= b) ? 1 : 0);
          end
        end
      end
    end
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule